// File: doc/BRIEF.md
# Serial-Bus Timeslot Enable Controller

This block sits in front of an HDLC core that is attached to a framed TDM serial bus. It decides when the core's transmit and receive sections are allowed to work. In external timing mode, two active-low pins drive the enables directly. In internal timing mode, the block counts bit positions from the frame pulse and raises both enables only during the channel that a 4-bit slot number selects. In internal mode it can also drive a programmable control byte onto channel 1 of the outgoing bus, MSB first.

An 8-bit control word sets the mode, the slot and the byte enable, and also holds a soft-reset bit. Setting that bit clears every other register and drops frame alignment. Reset is released only after the bit has been written as zero on two separate writes. Two state machines run the block:

- The reset machine has three states: `RS_RUN`, `RS_HOLD` and `RS_CLR1`. Its transitions are:
  - set-write, from any state to `RS_HOLD`;
  - first clear-write, `RS_HOLD` to `RS_CLR1`;
  - second clear-write, `RS_CLR1` to `RS_RUN`.
- The frame machine has two states: `FR_HUNT` and `FR_LOCK`. Its transitions are:
  - `FR_HUNT` to `FR_LOCK` on a bit tick that carries the frame pulse;
  - any state to `FR_HUNT` while soft reset is active.

Top module: `tsc_timeslot_ctrl`

## Requirements
- R1: After `rst_n` is released, `ctrl_rd` reads 0x00, `in_soft_reset` is 0, `cbus_oe` is 0, and the enables are off while both pins are high.
- R2: A write to address 0 with bit 7 = 1 enters soft reset. During soft reset the following hold:
  - `ctrl_rd` reads 0x80 and `in_soft_reset` is 1;
  - `tx_en`, `rx_en` and `cbus_oe` are 0;
  - the C-channel byte and the lower control bits are cleared, and writes to them are discarded;
  - frame alignment is lost.
- R3: Soft reset ends only on the second write of a control word with bit 7 = 0. A write with bit 7 = 1 restarts the count. The write that releases reset does not load its lower bits, so `ctrl_rd` reads 0x00 afterwards.
- R4: The control word has this layout: bit 6 selects internal timing, bit 5 enables the C-channel byte, bit 4 is a stored spare, and bits 3..0 give the slot number. Out of reset, `ctrl_rd` returns the last control word written.
- R5: With bit 6 = 0 and out of reset, `tx_en` equals the inverse of `tx_en_pin_n` and `rx_en` equals the inverse of `rx_en_pin_n`. The frame pulse has no effect on them.
- R6: Frame position works as follows:
  - a `bit_tick` together with `frame_pulse` sets the position to bit 0 of channel 0, and also re-aligns a running count;
  - every other `bit_tick` advances the position by one bit;
  - there are 8 bits per channel and 32 channels, and the count wraps after 256 bits;
  - before the first frame pulse after any reset, no internal-mode enable or C-channel output is given.
- R7: With bit 6 = 1, `tx_en` and `rx_en` are both 1 exactly while the current channel equals the slot number (0..15), and the pins are ignored.
- R8: With bits 6 and 5 = 1 and the frame aligned, `cbus_oe` is 1 during channel 1 only. During that channel, bit n of the channel drives `cbus_out` from C-channel byte bit 7-n.
- R9: With bit 6 = 0, bit 5 has no effect: `cbus_oe` stays 0.
- R10: When `reg_addr` is 0, a write goes to the control word. When `reg_addr` is 1, a write goes to the C-channel byte and leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control word, 1 C-channel byte |
| reg_wdata | input | 8 | Write data |
| ctrl_rd | output | 8 | Control word read-back |
| in_soft_reset | output | 1 | Soft reset active |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| frame_pulse | input | 1 | Frame start, qualified by bit_tick |
| tx_en_pin_n | input | 1 | External transmit enable, active low |
| rx_en_pin_n | input | 1 | External receive enable, active low |
| tx_en | output | 1 | Transmit section enable |
| rx_en | output | 1 | Receive section enable |
| cbus_oe | output | 1 | Outgoing bus drive enable for the C-channel byte |
| cbus_out | output | 1 | C-channel serial bit |

## Verification
The assertions check four things on every cycle:
- a set-write always lands in `RS_HOLD`, and `RS_RUN` is entered only from `RS_CLR1`;
- the registers stay clear while soft reset persists;
- each plain tick advances the frame position by exactly one bit;
- a frame pulse aligns the count to zero.

Other behaviour can only be shown by the bench's scenarios:
- the exact enable window for a slot, including slot 15 and the 256-bit wrap;
- the MSB-first order of the C-channel byte;
- that pins are ignored in internal mode;
- that writes are discarded during reset, including the release write.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int CTRL_W     = 8;
    localparam int B_SRST     = 7;
    localparam int B_INTERNAL = 6;
    localparam int B_CEN      = 5;
    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_CBYTE = 1'b1;

    typedef enum logic [1:0] {
        RS_RUN  = 2'd0,
        RS_HOLD = 2'd1,
        RS_CLR1 = 2'd2
    } rst_state_e;

    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_LOCK = 1'b1
    } frm_state_e;
endpackage

// File: rtl/tsc_reset_fsm.sv
module tsc_reset_fsm
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_srst_bit,
    output logic in_reset
);
    rst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (wr_srst_bit) begin
                state_d = RS_HOLD;
            end else begin
                unique case (state_q)
                    RS_RUN:  state_d = RS_RUN;
                    RS_HOLD: state_d = RS_CLR1;
                    RS_CLR1: state_d = RS_RUN;
                    default: state_d = RS_HOLD;
                endcase
            end
        end
    end

    always_comb begin
        in_reset = (state_q != RS_RUN);
    end

    AST_SET_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_srst_bit) |=> (state_q == RS_HOLD)); // R2
    AST_RELEASE_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_RUN && $past(state_q) != RS_RUN) |-> ($past(state_q) == RS_CLR1)); // R3
endmodule

// File: rtl/tsc_frame_cnt.sv
module tsc_frame_cnt
    import tsc_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_tick,
    input  logic              frame_pulse,
    output logic              locked,
    output logic [CHAN_W-1:0] chan,
    output logic [BIT_W-1:0]  bitn
);
    localparam int POS_W = CHAN_W + BIT_W;

    frm_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_HUNT;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (clr) begin
            state_d = FR_HUNT;
            pos_d   = '0;
        end else if (bit_tick) begin
            unique case (state_q)
                FR_HUNT: begin
                    if (frame_pulse) begin
                        state_d = FR_LOCK;
                        pos_d   = '0;
                    end
                end
                FR_LOCK: begin
                    pos_d = frame_pulse ? '0 : pos_q + 1'b1;
                end
                default: state_d = FR_HUNT;
            endcase
        end
    end

    always_comb begin
        locked = (state_q == FR_LOCK);
        chan   = pos_q[POS_W-1:BIT_W];
        bitn   = pos_q[BIT_W-1:0];
    end

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bit_tick && !frame_pulse && !clr) |=> ({chan, bitn} == $past({chan, bitn}) + 1'b1)); // R6
    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_pulse && !clr) |=> (locked && chan == '0 && bitn == '0)); // R6
endmodule

// File: rtl/tsc_slot_decode.sv
module tsc_slot_decode
    import tsc_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int BIT_W  = 3,
    parameter int SLOT_W = 4,
    parameter int C_SLOT = 1
) (
    input  logic                   in_reset,
    input  logic                   internal,
    input  logic                   c_en,
    input  logic [SLOT_W-1:0]      slot,
    input  logic [(1<<BIT_W)-1:0]  cbyte,
    input  logic                   locked,
    input  logic [CHAN_W-1:0]      chan,
    input  logic [BIT_W-1:0]       bitn,
    input  logic [1:0]             pin_n,
    output logic [1:0]             en,
    output logic                   cbus_oe,
    output logic                   cbus_out
);
    logic in_slot;
    logic in_cslot;

    always_comb begin
        in_slot  = locked && (chan == CHAN_W'(slot));
        in_cslot = locked && (chan == CHAN_W'(C_SLOT));
    end

    for (genvar d = 0; d < 2; d++) begin : g_dir
        always_comb begin
            if (in_reset)      en[d] = 1'b0;
            else if (internal) en[d] = in_slot;
            else               en[d] = ~pin_n[d];
        end
    end

    always_comb begin
        cbus_oe  = !in_reset && internal && c_en && in_cslot;
        cbus_out = cbus_oe ? cbyte[~bitn] : 1'b0;
    end
endmodule

// File: rtl/tsc_timeslot_ctrl.sv
module tsc_timeslot_ctrl
    import tsc_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int BIT_W  = 3,
    parameter int SLOT_W = 4,
    parameter int C_SLOT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] ctrl_rd,
    output logic       in_soft_reset,
    input  logic       bit_tick,
    input  logic       frame_pulse,
    input  logic       tx_en_pin_n,
    input  logic       rx_en_pin_n,
    output logic       tx_en,
    output logic       rx_en,
    output logic       cbus_oe,
    output logic       cbus_out
);
    localparam int BYTE_W = 1 << BIT_W;

    logic [CTRL_W-2:0] ctrl_lo;
    logic [BYTE_W-1:0] cbyte;
    logic              in_reset;
    logic              ctrl_wr;
    logic              locked;
    logic [CHAN_W-1:0] chan;
    logic [BIT_W-1:0]  bitn;
    logic [1:0]        en;

    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    end

    tsc_reset_fsm u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wr_srst_bit (reg_wdata[B_SRST]),
        .in_reset    (in_reset)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_lo <= '0;
            cbyte   <= '0;
        end else if (in_reset) begin
            ctrl_lo <= '0;
            cbyte   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL && !reg_wdata[B_SRST]) ctrl_lo <= reg_wdata[CTRL_W-2:0];
            if (reg_addr == ADDR_CBYTE)                      cbyte   <= reg_wdata[BYTE_W-1:0];
        end
    end

    tsc_frame_cnt #(.CHAN_W(CHAN_W), .BIT_W(BIT_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (in_reset),
        .bit_tick    (bit_tick),
        .frame_pulse (frame_pulse),
        .locked      (locked),
        .chan        (chan),
        .bitn        (bitn)
    );

    tsc_slot_decode #(.CHAN_W(CHAN_W), .BIT_W(BIT_W), .SLOT_W(SLOT_W), .C_SLOT(C_SLOT)) u_dec (
        .in_reset (in_reset),
        .internal (ctrl_lo[B_INTERNAL]),
        .c_en     (ctrl_lo[B_CEN]),
        .slot     (ctrl_lo[SLOT_W-1:0]),
        .cbyte    (cbyte),
        .locked   (locked),
        .chan     (chan),
        .bitn     (bitn),
        .pin_n    ({rx_en_pin_n, tx_en_pin_n}),
        .en       (en),
        .cbus_oe  (cbus_oe),
        .cbus_out (cbus_out)
    );

    always_comb begin
        tx_en         = en[0];
        rx_en         = en[1];
        in_soft_reset = in_reset;
        ctrl_rd       = in_reset ? 8'h80 : {1'b0, ctrl_lo};
    end

    AST_REGS_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_reset && $past(in_reset)) |-> (ctrl_lo == '0 && cbyte == '0)); // R2
    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |-> (!tx_en && !rx_en && !cbus_oe)); // R2
endmodule

// File: tb/test_tsc_timeslot_ctrl.sv
module test_tsc_timeslot_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctrl_rd;
    logic       in_soft_reset;
    logic       bit_tick = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       tx_en_pin_n = 1'b1;
    logic       rx_en_pin_n = 1'b1;
    logic       tx_en, rx_en, cbus_oe, cbus_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tsc_timeslot_ctrl i_tsc_timeslot_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .in_soft_reset(in_soft_reset),
        .bit_tick(bit_tick), .frame_pulse(frame_pulse),
        .tx_en_pin_n(tx_en_pin_n), .rx_en_pin_n(rx_en_pin_n),
        .tx_en(tx_en), .rx_en(rx_en), .cbus_oe(cbus_oe), .cbus_out(cbus_out)
    );

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick(input logic fp);
        @(negedge clk);
        bit_tick = 1'b1; frame_pulse = fp;
        @(negedge clk);
        bit_tick = 1'b0; frame_pulse = 1'b0;
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    task automatic t_reset;
        chk("R1", "ctrl_rd", ctrl_rd, 8'h00);
        chk("R1", "in_soft_reset", {7'd0, in_soft_reset}, 8'h00);
        chk("R1", "tx_en", {7'd0, tx_en}, 8'h00);
        chk("R1", "rx_en", {7'd0, rx_en}, 8'h00);
        chk("R1", "cbus_oe", {7'd0, cbus_oe}, 8'h00);
    endtask

    task automatic t_regs;
        wr(1'b0, 8'h5A);
        chk("R4", "ctrl readback", ctrl_rd, 8'h5A);
        wr(1'b1, 8'h3C);
        chk("R10", "ctrl after cbyte write", ctrl_rd, 8'h5A);
    endtask

    task automatic t_ext;
        wr(1'b0, 8'h00);
        tx_en_pin_n = 1'b0; rx_en_pin_n = 1'b1; #2;
        chk("R5", "tx follows pin", {7'd0, tx_en}, 8'h01);
        chk("R5", "rx follows pin", {7'd0, rx_en}, 8'h00);
        tx_en_pin_n = 1'b1; rx_en_pin_n = 1'b0; #2;
        chk("R5", "tx follows pin", {7'd0, tx_en}, 8'h00);
        chk("R5", "rx follows pin", {7'd0, rx_en}, 8'h01);
        tick(1'b1);
        chk("R5", "frame pulse no effect", {6'd0, rx_en, tx_en}, 8'h02);
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h20);
        tick(1'b1); adv(8);
        chk("R9", "no C output in ext mode", {7'd0, cbus_oe}, 8'h00);
        tx_en_pin_n = 1'b1; rx_en_pin_n = 1'b1;
    endtask

    task automatic t_int;
        wr(1'b0, 8'h43);
        tx_en_pin_n = 1'b0; rx_en_pin_n = 1'b0;
        tick(1'b1);
        chk("R7", "ch0 slot3 pins ignored", {6'd0, rx_en, tx_en}, 8'h00);
        adv(24);
        chk("R7", "ch3 start", {6'd0, rx_en, tx_en}, 8'h03);
        adv(7);
        chk("R7", "ch3 last bit", {6'd0, rx_en, tx_en}, 8'h03);
        adv(1);
        chk("R7", "ch4 off", {6'd0, rx_en, tx_en}, 8'h00);
        wr(1'b0, 8'h40);
        tick(1'b1);
        chk("R6", "slot0 at frame start", {7'd0, tx_en}, 8'h01);
        adv(8);
        chk("R6", "slot0 end", {7'd0, tx_en}, 8'h00);
        adv(248);
        chk("R6", "wrap after 256 bits", {7'd0, tx_en}, 8'h01);
        wr(1'b0, 8'h4F);
        tick(1'b1); adv(120);
        chk("R7", "slot15 on", {7'd0, tx_en}, 8'h01);
        adv(8);
        chk("R7", "ch16 off", {7'd0, tx_en}, 8'h00);
        tx_en_pin_n = 1'b1; rx_en_pin_n = 1'b1;
    endtask

    task automatic t_cchan;
        logic [7:0] cb;
        cb = 8'hA5;
        wr(1'b1, cb);
        wr(1'b0, 8'h60);
        tick(1'b1);
        chk("R8", "oe off in ch0", {7'd0, cbus_oe}, 8'h00);
        adv(8);
        for (int n = 0; n < 8; n++) begin
            chk("R8", "oe in ch1", {7'd0, cbus_oe}, 8'h01);
            chk("R8", "bit MSB first", {7'd0, cbus_out}, {7'd0, cb[7-n]});
            adv(1);
        end
        chk("R8", "oe off in ch2", {7'd0, cbus_oe}, 8'h00);
        tick(1'b1); adv(8);
        chk("R6", "realign mid-frame", {7'd0, cbus_oe}, 8'h01);
    endtask

    task automatic t_soft;
        wr(1'b0, 8'h00);
        tx_en_pin_n = 1'b0; #2;
        chk("R5", "ext tx before reset", {7'd0, tx_en}, 8'h01);
        wr(1'b0, 8'h80);
        chk("R2", "ctrl_rd in reset", ctrl_rd, 8'h80);
        chk("R2", "flag", {7'd0, in_soft_reset}, 8'h01);
        chk("R2", "tx_en off", {7'd0, tx_en}, 8'h00);
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h00);
        chk("R3", "one clear not enough", ctrl_rd, 8'h80);
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h00);
        chk("R3", "count restarted", ctrl_rd, 8'h80);
        wr(1'b0, 8'h4F);
        chk("R3", "released, low bits not loaded", ctrl_rd, 8'h00);
        chk("R3", "flag clear", {7'd0, in_soft_reset}, 8'h00);
        tx_en_pin_n = 1'b1;
        wr(1'b0, 8'h60);
        adv(10);
        chk("R6", "no output before frame pulse", {7'd0, cbus_oe}, 8'h00);
        tick(1'b1); adv(8);
        for (int n = 0; n < 8; n++) begin
            chk("R2", "cbyte cleared oe", {7'd0, cbus_oe}, 8'h01);
            chk("R2", "cbyte cleared bit", {7'd0, cbus_out}, 8'h00);
            adv(1);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_ext();
        t_int();
        t_cchan();
        t_soft();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule